// File: doc/BRIEF.md
# Serial Line Command Parser

This block is a text command front end for a two-channel pattern store. It receives bytes over an asynchronous serial line and collects them into lines. When a line ends, the block decodes it as one of a small set of upper-case commands. A decoded command either issues a word write into the pattern memory of one of the two channels or updates a control register: pattern length, output run mode or a clear strobe for both memories. Both the memory and the output engine are outside this block.

Every received byte is echoed on the transmit line. After each line, the block sends an error text if the line was rejected, and then a single prompt character. A host should wait for the prompt before it sends the next line. The command words are `LD0` and `LD1` to open a load session, `WD_hhhh_hhhh` to write a word, `END` to close the session, `LEN_hhhh_hhhh` to set the length, `CLR` to clear both memories, and `RUN`, `ONE` and `HALT` to set the mode.

Top module: `linecmd_parser`

## Requirements
- R1: Both serial directions use one start bit (low), eight data bits with the LSB first, and one stop bit (high), with no parity, at `CLKS_PER_BIT` clocks per bit. The transmit line idles high.
- R2: Every received byte is echoed unchanged and in arrival order. The echo of a line is sent before that line's response.
- R3: A line is complete only when LF (0x0A) arrives directly after CR (0x0D). A line that ends in a bare LF, that has any other character after its CR, or that contains a lower-case letter is rejected.
- R4: `LD0` or `LD1` opens a load session on channel 0 or channel 1 and restarts the write address at 0, even if a session is already open.
- R5: During an open session, `WD_hhhh_hhhh` (upper-case hex, first digit most significant) produces one single-cycle `wrEn` pulse. The pulse carries the session channel on `wrChan`, the next sequential address on `wrAddr` and the 32-bit value on `wrData`.
- R6: `END` closes the session and is accepted at any fill level. A word line received with no session open is rejected and writes nothing.
- R7: After `WORDS` writes in one session, further word lines are accepted but discarded. They produce no `wrEn`, and `wrAddr` keeps its last value.
- R8: `LEN_hhhh_hhhh` loads the 32-bit value into `patLen`.
- R9: `CLR` produces a single-cycle pulse on `memClr`.
- R10: `RUN`, `ONE` and `HALT` set `runMode` to 1, 2 and 0 respectively. The value 3 never occurs.
- R11: Any other line is rejected. This includes the empty line, an over-long line, and a line with a non-hex character in a data or length field. A rejected line is answered with `INVALID DATA` CR LF and changes no output or register.
- R12: Every completed line is answered last with the prompt character `>` (0x3E).
- R13: During reset, `txd` is high, `runMode` and `patLen` are 0, no session is open, and `wrEn` and `memClr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| wrEn | output | 1 | Pattern memory write strobe |
| wrChan | output | 1 | Channel of the write |
| wrAddr | output | ADDR_W | Word address of the write |
| wrData | output | 32 | Word value of the write |
| memClr | output | 1 | Strobe that clears both channel memories |
| patLen | output | 32 | Pattern length register |
| runMode | output | 2 | 0 halted, 1 looping, 2 single shot |

## Verification
The receiver flags a byte at the middle of its stop bit. The decode strobe follows one cycle later. `wrEn`, `memClr`, `patLen` and `runMode` change two cycles after that flag. The echo and the response then take whole serial frames each. The bench therefore decodes `txd` with its own receiver, and only after the prompt byte has arrived does it compare the full echoed and answered byte string. At that point it also samples the outputs on the falling clock edge, and it compares the write pulses that a falling-edge monitor counted during the line. By then every register update for the line has long settled, so no check depends on an exact edge.

// File: rtl/lcp_pkg.sv
package lcp_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_LOOP   = 2'd1,
    MODE_SINGLE = 2'd2
  } run_mode_e;

  // one-cycle strobes from the line decoder to the datapath
  typedef struct packed {
    logic      wordWr;
    logic      sessOpen;
    logic      sessChan;
    logic      sessClose;
    logic      lenWr;
    logic      memClr;
    logic      modeWr;
    run_mode_e modeVal;
    logic      respOk;
    logic      respErr;
  } lcp_strb_t;

  // longest legal line: LEN_hhhh_hhhh
  localparam int LINE_MAX = 13;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_US = 8'h5F;
  // response text: error string followed by the prompt
  localparam logic [3:0] MSG_ERR_IDX    = 4'd0;
  localparam logic [3:0] MSG_PROMPT_IDX = 4'd14;

  function automatic logic isHexDigit(input logic [7:0] c);
    return (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h46);
  endfunction

  function automatic logic [3:0] hexNibble(input logic [7:0] c);
    return (c <= 8'h39) ? c[3:0] : c[3:0] + 4'd9;
  endfunction

  function automatic logic [7:0] msgByte(input logic [3:0] idx);
    case (idx)
      4'd0:  return 8'h49; // I
      4'd1:  return 8'h4E; // N
      4'd2:  return 8'h56; // V
      4'd3:  return 8'h41; // A
      4'd4:  return 8'h4C; // L
      4'd5:  return 8'h49; // I
      4'd6:  return 8'h44; // D
      4'd7:  return 8'h20; // space
      4'd8:  return 8'h44; // D
      4'd9:  return 8'h41; // A
      4'd10: return 8'h54; // T
      4'd11: return 8'h41; // A
      4'd12: return CH_CR;
      4'd13: return CH_LF;
      default: return 8'h3E; // >
    endcase
  endfunction

endpackage

// File: rtl/lcp_uart_rx.sv
module lcp_uart_rx #(
  parameter int CLKS_PER_BIT = 13021
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxd,
  output logic       rxValid,
  output logic [7:0] rxByte
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(CLKS_PER_BIT / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  rx_state_e        state;
  logic [CNT_W-1:0] clkCnt;
  logic [2:0]       bitIdx;
  logic [7:0]       shReg;
  logic             rxMeta, rxSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      clkCnt  <= '0;
      bitIdx  <= '0;
      shReg   <= '0;
      rxValid <= 1'b0;
      rxByte  <= '0;
    end else begin
      rxValid <= 1'b0;
      case (state)
        RX_IDLE: begin
          clkCnt <= '0;
          if (!rxSync) state <= RX_START;
        end
        RX_START: begin
          if (clkCnt == MID) begin
            clkCnt <= '0;
            bitIdx <= '0;
            state  <= rxSync ? RX_IDLE : RX_DATA;
          end else clkCnt <= clkCnt + 1'b1;
        end
        RX_DATA: begin
          if (clkCnt == LAST) begin
            clkCnt <= '0;
            shReg  <= {rxSync, shReg[7:1]};
            if (bitIdx == 3'd7) state <= RX_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else clkCnt <= clkCnt + 1'b1;
        end
        default: begin
          if (clkCnt == LAST) begin
            clkCnt <= '0;
            state  <= RX_IDLE;
            if (rxSync) begin
              rxValid <= 1'b1;
              rxByte  <= shReg;
            end
          end else clkCnt <= clkCnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lcp_uart_tx.sv
module lcp_uart_tx #(
  parameter int CLKS_PER_BIT = 13021
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txValid,
  input  logic [7:0] txByte,
  output logic       txReady,
  output logic       txd
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [9:0]       frame;
  logic [3:0]       bitCnt;
  logic [CNT_W-1:0] clkCnt;
  logic             busy;

  assign txReady = !busy;
  assign txd     = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frame  <= '1;
      bitCnt <= '0;
      clkCnt <= '0;
      busy   <= 1'b0;
    end else if (!busy) begin
      if (txValid) begin
        frame  <= {1'b1, txByte, 1'b0};
        bitCnt <= '0;
        clkCnt <= '0;
        busy   <= 1'b1;
      end
    end else if (clkCnt == LAST) begin
      clkCnt <= '0;
      frame  <= {1'b1, frame[9:1]};
      if (bitCnt == 4'd9) busy <= 1'b0;
      else bitCnt <= bitCnt + 1'b1;
    end else begin
      clkCnt <= clkCnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcp_ctrl.sv
module lcp_ctrl
  import lcp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        sessActive,
  output lcp_strb_t   strb,
  output logic [31:0] strbVal
);
  localparam int LEN_W = $clog2(LINE_MAX + 1);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(LINE_MAX);

  logic [7:0]       lineBuf [LINE_MAX];
  logic [LEN_W-1:0] lineLen;
  logic             sawCr;
  logic             lineBad;

  lcp_strb_t   dec;
  logic [31:0] word;
  logic        allHex;
  logic [3:0]  base;
  logic [3:0]  pos;
  logic [23:0] head3;
  logic [31:0] head4;
  logic        lineGood;

  // line assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineLen <= '0;
      sawCr   <= 1'b0;
      lineBad <= 1'b0;
    end else if (rxValid) begin
      if (rxByte == CH_LF) begin
        lineLen <= '0;
        sawCr   <= 1'b0;
        lineBad <= 1'b0;
      end else if (rxByte == CH_CR) begin
        if (sawCr) lineBad <= 1'b1;
        sawCr <= 1'b1;
      end else if (sawCr || lineLen == LEN_CAP) begin
        lineBad <= 1'b1;
      end else begin
        lineLen <= lineLen + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rxValid && rxByte != CH_LF && rxByte != CH_CR && !sawCr && lineLen != LEN_CAP)
      lineBuf[lineLen] <= rxByte;
  end

  // decode of the assembled line
  always_comb begin
    head3  = {lineBuf[0], lineBuf[1], lineBuf[2]};
    head4  = {lineBuf[0], lineBuf[1], lineBuf[2], lineBuf[3]};
    base   = (lineBuf[0] == 8'h57) ? 4'd3 : 4'd4;
    word   = '0;
    allHex = 1'b1;
    pos    = '0;
    for (int i = 0; i < 8; i++) begin
      pos    = base + 4'(i) + ((i >= 4) ? 4'd1 : 4'd0);
      allHex = allHex & isHexDigit(lineBuf[pos]);
      word   = {word[27:0], hexNibble(lineBuf[pos])};
    end
    lineGood = sawCr && !lineBad;

    dec = '0;
    dec.respErr = 1'b1;
    if (lineGood) begin
      if (lineLen == LEN_W'(3)) begin
        dec.respErr = 1'b0;
        case (head3)
          "LD0":   dec.sessOpen = 1'b1;
          "LD1":   begin dec.sessOpen = 1'b1; dec.sessChan = 1'b1; end
          "END":   dec.sessClose = 1'b1;
          "CLR":   dec.memClr = 1'b1;
          "RUN":   begin dec.modeWr = 1'b1; dec.modeVal = MODE_LOOP; end
          "ONE":   begin dec.modeWr = 1'b1; dec.modeVal = MODE_SINGLE; end
          default: dec.respErr = 1'b1;
        endcase
      end else if (lineLen == LEN_W'(4) && head4 == "HALT") begin
        dec.respErr = 1'b0;
        dec.modeWr  = 1'b1;
        dec.modeVal = MODE_IDLE;
      end else if (lineLen == LEN_W'(12) && head3 == "WD_" && lineBuf[7] == CH_US
                   && allHex && sessActive) begin
        dec.respErr = 1'b0;
        dec.wordWr  = 1'b1;
      end else if (lineLen == LEN_W'(13) && head4 == "LEN_" && lineBuf[8] == CH_US
                   && allHex) begin
        dec.respErr = 1'b0;
        dec.lenWr   = 1'b1;
      end
    end
    dec.respOk = !dec.respErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strb    <= '0;
      strbVal <= '0;
    end else begin
      strb <= '0;
      if (rxValid && rxByte == CH_LF) begin
        strb    <= dec;
        strbVal <= word;
      end
    end
  end
endmodule

// File: rtl/lcp_data.sv
module lcp_data
  import lcp_pkg::*;
#(
  parameter  int WORDS      = 8192,
  parameter  int FIFO_DEPTH = 32,
  localparam int ADDR_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcp_strb_t         strb,
  input  logic [31:0]       strbVal,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  input  logic              txReady,
  output logic              txValid,
  output logic [7:0]        txByte,
  output logic              sessActive,
  output logic              wrEn,
  output logic              wrChan,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              memClr,
  output logic [31:0]       patLen,
  output logic [1:0]        runMode
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam logic [PTR_W:0]  FIFO_CAP = (PTR_W + 1)'(FIFO_DEPTH);
  localparam logic [ADDR_W:0] WORD_CAP = (ADDR_W + 1)'(WORDS);

  // session and register state
  logic        sessChanR;
  logic [ADDR_W:0] wrCount;
  run_mode_e   modeR;

  assign runMode = modeR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sessActive <= 1'b0;
      sessChanR  <= 1'b0;
      wrCount    <= '0;
      wrEn       <= 1'b0;
      wrChan     <= 1'b0;
      wrAddr     <= '0;
      wrData     <= '0;
      memClr     <= 1'b0;
      patLen     <= '0;
      modeR      <= MODE_IDLE;
    end else begin
      wrEn   <= 1'b0;
      memClr <= strb.memClr;
      if (strb.sessOpen) begin
        sessActive <= 1'b1;
        sessChanR  <= strb.sessChan;
        wrCount    <= '0;
      end
      if (strb.sessClose) sessActive <= 1'b0;
      if (strb.wordWr && wrCount < WORD_CAP) begin
        wrEn    <= 1'b1;
        wrChan  <= sessChanR;
        wrAddr  <= wrCount[ADDR_W-1:0];
        wrData  <= strbVal;
        wrCount <= wrCount + 1'b1;
      end
      if (strb.lenWr)  patLen <= strbVal;
      if (strb.modeWr) modeR  <= strb.modeVal;
    end
  end

  // response text sequencer
  logic       msgBusy;
  logic [3:0] msgIdx;
  logic       fifoFull, fifoEmpty;
  logic       echoPush, msgPush, push, pop;
  logic [7:0] pushByte;

  assign echoPush = rxValid && !fifoFull;
  assign msgPush  = msgBusy && !rxValid && !fifoFull;
  assign push     = echoPush || msgPush;
  assign pushByte = rxValid ? rxByte : msgByte(msgIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgBusy <= 1'b0;
      msgIdx  <= '0;
    end else if (strb.respErr) begin
      msgBusy <= 1'b1;
      msgIdx  <= MSG_ERR_IDX;
    end else if (strb.respOk) begin
      msgBusy <= 1'b1;
      msgIdx  <= MSG_PROMPT_IDX;
    end else if (msgPush) begin
      if (msgIdx == MSG_PROMPT_IDX) msgBusy <= 1'b0;
      else msgIdx <= msgIdx + 1'b1;
    end
  end

  // transmit queue
  logic [7:0]       fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   fill;

  assign fifoFull  = (fill == FIFO_CAP);
  assign fifoEmpty = (fill == '0);
  assign txValid   = !fifoEmpty;
  assign txByte    = fifoMem[rdPtr];
  assign pop       = txReady && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (push) fifoMem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/linecmd_parser.sv
module linecmd_parser
  import lcp_pkg::*;
#(
  parameter  int CLKS_PER_BIT = 13021,
  parameter  int WORDS        = 8192,
  parameter  int FIFO_DEPTH   = 32,
  localparam int ADDR_W       = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxd,
  output logic              txd,
  output logic              wrEn,
  output logic              wrChan,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              memClr,
  output logic [31:0]       patLen,
  output logic [1:0]        runMode
);
  logic        rxValid;
  logic [7:0]  rxByte;
  logic        txValid, txReady;
  logic [7:0]  txByte;
  logic        sessActive;
  lcp_strb_t   strb;
  logic [31:0] strbVal;

  lcp_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rstN(rstN), .rxd(rxd), .rxValid(rxValid), .rxByte(rxByte)
  );

  lcp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte),
    .sessActive(sessActive), .strb(strb), .strbVal(strbVal)
  );

  lcp_data #(.WORDS(WORDS), .FIFO_DEPTH(FIFO_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .strbVal(strbVal),
    .rxValid(rxValid), .rxByte(rxByte), .txReady(txReady),
    .txValid(txValid), .txByte(txByte), .sessActive(sessActive),
    .wrEn(wrEn), .wrChan(wrChan), .wrAddr(wrAddr), .wrData(wrData),
    .memClr(memClr), .patLen(patLen), .runMode(runMode)
  );

  lcp_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rstN(rstN), .txValid(txValid), .txByte(txByte),
    .txReady(txReady), .txd(txd)
  );
endmodule

// File: rtl/lcp_chk.sv
module lcp_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              memClr,
  input logic [31:0]       patLen,
  input logic [1:0]        runMode
);
  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R7
  addr_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wrAddr) |-> wrEn);

  // R8
  len_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(patLen) |-> (!wrEn && !memClr));

  // R9
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memClr |=> !memClr);

  // R10
  mode_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    runMode != 2'd3);
endmodule

bind linecmd_parser lcp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .memClr(memClr), .patLen(patLen), .runMode(runMode)
);

// File: tb/linecmd_parser_tb.sv
module linecmd_parser_tb;
  localparam int CPB    = 8;
  localparam int WORDS  = 8;
  localparam int ADDR_W = $clog2(WORDS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxd = 1'b1;
  logic txd, wrEn, wrChan, memClr;
  logic [ADDR_W-1:0] wrAddr;
  logic [31:0] wrData, patLen;
  logic [1:0]  runMode;

  always #4 clk = ~clk;

  linecmd_parser #(.CLKS_PER_BIT(CPB), .WORDS(WORDS), .FIFO_DEPTH(32)) u_dut (
    .clk(clk), .rstN(rstN), .rxd(rxd), .txd(txd), .wrEn(wrEn), .wrChan(wrChan),
    .wrAddr(wrAddr), .wrData(wrData), .memClr(memClr), .patLen(patLen),
    .runMode(runMode)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // monitor of write and clear pulses
  int          wrN = 0;
  int          clrN = 0;
  logic        seenChan;
  logic [ADDR_W-1:0] seenAddr;
  logic [31:0] seenData;
  always @(negedge clk) begin
    if (rstN && wrEn) begin
      wrN++;
      seenChan = wrChan;
      seenAddr = wrAddr;
      seenData = wrData;
    end
    if (rstN && memClr) clrN++;
  end

  // serial receiver of the transmit line
  logic [7:0] rxLog [0:4095];
  int logN = 0;
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rstN && txd === 1'b0) begin
        repeat (CPB / 2) @(negedge clk);
        b = '0;
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = txd;
        end
        repeat (CPB) @(negedge clk);
        rxLog[logN] = b;
        logN++;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  function automatic string hx4(input logic [15:0] v);
    string s = "";
    for (int i = 3; i >= 0; i--) begin
      logic [3:0] n;
      n = v[i*4 +: 4];
      s = $sformatf("%s%c", s, (n < 4'd10) ? 8'h30 + 8'(n) : 8'h37 + 8'(n));
    end
    return s;
  endfunction

  // model state
  bit          mSess = 0;
  int          mChan = 0;
  int          mCnt  = 0;
  logic [31:0] mLen  = '0;
  logic [1:0]  mMode = 2'd0;

  task automatic runRaw(input string raw, input bit expErr, input string tag);
    int start;
    int mism;
    string e;
    start = logN;
    wrN = 0;
    clrN = 0;
    for (int i = 0; i < raw.len(); i++) sendByte(raw[i]);
    forever begin
      @(negedge clk);
      if (logN > start && rxLog[logN-1] == 8'h3E) break;
    end
    e = raw;
    if (expErr) e = {e, "INVALID DATA\r\n"};
    e = {e, ">"};
    mism = -1;
    if (logN - start != e.len()) mism = 0;
    else
      for (int i = 0; i < e.len(); i++)
        if (mism < 0 && rxLog[start+i] != e[i]) mism = i;
    // R1 R2 R12 plus the line's own requirement
    check(mism < 0, {"R1 R2 R12 ", tag}, "echo/response byte",
          (mism >= 0 && start + mism < logN) ? 32'(rxLog[start+mism]) : 32'(logN - start),
          (mism >= 0 && mism < e.len()) ? 32'(e[mism]) : 32'(e.len()));
    repeat (4) @(negedge clk);
  endtask

  task automatic runLine(input string s, input bit expErr, input string tag);
    runRaw({s, "\r\n"}, expErr, tag);
  endtask

  task automatic expectQuiet(input string tag);
    check(wrN == 0 && clrN == 0, tag, "no strobe", 32'(wrN + clrN), 0);
    check(patLen == mLen, tag, "patLen kept", patLen, mLen);
    check(runMode == mMode, tag, "runMode kept", 32'(runMode), 32'(mMode));
  endtask

  task automatic doLoad(input int ch);
    runLine($sformatf("LD%0d", ch), 0, "R4");
    mSess = 1; mChan = ch; mCnt = 0;
    check(wrN == 0, "R4", "no write on open", 32'(wrN), 0);
  endtask

  task automatic doWord(input logic [31:0] d);
    bit expWr;
    expWr = mSess && mCnt < WORDS;
    runLine({"WD_", hx4(d[31:16]), "_", hx4(d[15:0])}, !mSess, mSess ? "R5" : "R6");
    if (!mSess) expectQuiet("R6");
    else if (expWr) begin
      check(wrN == 1, "R5", "write count", 32'(wrN), 1);
      check(seenChan == mChan[0], "R5", "channel", 32'(seenChan), 32'(mChan));
      check(seenAddr == ADDR_W'(mCnt), "R5", "address", 32'(seenAddr), 32'(mCnt));
      check(seenData == d, "R5", "data", seenData, d);
      mCnt++;
    end else begin
      check(wrN == 0, "R7", "discarded write", 32'(wrN), 0);
      check(wrAddr == ADDR_W'(WORDS - 1), "R7", "address held", 32'(wrAddr), WORDS - 1);
    end
  endtask

  task automatic doLen(input logic [31:0] v);
    runLine({"LEN_", hx4(v[31:16]), "_", hx4(v[15:0])}, 0, "R8");
    mLen = v;
    check(patLen == v, "R8", "patLen", patLen, v);
  endtask

  task automatic doMode(input string s, input logic [1:0] v);
    runLine(s, 0, "R10");
    mMode = v;
    check(runMode == v, "R10", s, 32'(runMode), 32'(v));
  endtask

  task automatic doBad(input string raw, input string tag);
    runRaw(raw, 1, tag);
    expectQuiet(tag);
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    string s;
    logic [31:0] d;
    void'($urandom(32'd2718));
    repeat (10) @(negedge clk);
    // R13 reset state
    check(txd == 1'b1, "R13", "txd idle", 32'(txd), 1);
    check(runMode == 2'd0 && patLen == 0, "R13", "registers", patLen | 32'(runMode), 0);
    check(!wrEn && !memClr, "R13", "strobes", 32'({wrEn, memClr}), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);

    doWord($urandom);                // R6 no session yet
    doLoad(0);
    for (int i = 0; i < 6; i++) doWord($urandom);   // R5
    runLine("END", 0, "R6");
    mSess = 0;
    expectQuiet("R6");
    doWord($urandom);                // R6 after close

    doLoad(1);
    doWord(32'h0000_0000);
    doWord(32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) doWord($urandom);
    doWord(32'hA5A5_5A5A);           // R7 ninth word discarded
    doWord($urandom);                // R7 still full
    doLoad(1);                       // R4 restart at address 0
    doWord(32'h1234_ABCD);
    runLine("END", 0, "R6");
    mSess = 0;

    for (int i = 0; i < 3; i++) doLen($urandom);
    doMode("RUN", 2'd1);
    doMode("ONE", 2'd2);
    doMode("HALT", 2'd0);
    doMode("RUN", 2'd1);
    runLine("CLR", 0, "R9");
    check(clrN == 1 && wrN == 0, "R9", "clear pulses", 32'(clrN), 1);

    // R3 framing and case rules
    doBad("run\r\n", "R3");
    doBad("HALT\n", "R3");
    doBad("HALT\rX\r\n", "R3");
    // R11 unknown, empty, long, non-hex fields
    doBad("FOO\r\n", "R11");
    doBad("\r\n", "R11");
    doBad("LEN_0000_00000\r\n", "R11");
    doBad("LEN_00g0_0001\r\n", "R11");
    doLoad(0);
    for (int i = 0; i < 4; i++) begin
      int p;
      d = $urandom;
      s = {"WD_", hx4(d[31:16]), "_", hx4(d[15:0])};
      p = 3 + int'($urandom % 8);
      if (p >= 7) p++;
      s.putc(p, (i % 2 == 0) ? 8'h47 : 8'h61);   // 'G' or 'a'
      doBad({s, "\r\n"}, "R11");
    end
    doWord($urandom);                // address still starts at 0
    doWord($urandom);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule